// File: doc/BRIEF.md
# Two-Strobe Transmit Word Buffer

This block sits between a host bus and a serial line transmitter. The host builds each 31-bit transmit word from two 16-bit halves on one shared bus. It pulses a low-half strobe first and a high-half strobe second. On the high-half strobe the block writes the assembled word into the next free slot of an eight-entry queue. The host takes no further action for that write.

The serializer drains the queue through a one-cycle pop request. The popped word comes out registered one cycle later, together with a valid pulse. An occupancy counter tracks how many loaded words have not yet been taken. A transmitter-ready flag is high exactly while that count is zero, so the host knows when every queued word has gone out. While the queue is full, further high-half strobes are dropped and stored words stay intact.

Top module: `txb_two_strobe_buffer`

## Requirements
- R1: A high-half strobe that follows a low-half strobe commits one word. Bits [15:0] of the word are the bus value captured at the low-half strobe, and bits [30:16] are bus bits [14:0] at the high-half strobe.
- R2: Words leave in the order they were committed. A pop request in cycle t on a non-empty queue gives `rd_valid` high and the oldest word on `rd_word` in cycle t+1.
- R3: Starting from an empty queue, eight consecutive commits are all stored and are all returned by later pops.
- R4: A commit attempted while eight words are held is discarded. No stored word is changed or lost, and the next pops return the original eight words.
- R5: `tx_ready` is high exactly when the queue holds no words. It goes low in the cycle after the first commit and goes high in the cycle after the pop that takes the last word.
- R6: A high-half strobe with no low half pending commits nothing.
- R7: A second low-half strobe before the high-half strobe replaces the pending low half, and only the newer value is committed.
- R8: Bus bit 15 has no effect on the word during a high-half strobe.
- R9: A pop request on an empty queue gives no `rd_valid` pulse and leaves the queue unchanged.
- R10: After reset the queue is empty, no low half is pending, `tx_ready` is high and `rd_valid` is low.
- R11: When both strobes arrive in the same cycle, the high-half strobe commits using the previously pending low half. The new low half then becomes pending.
- R12: A commit and a pop in the same cycle both take effect. Whether a commit fits depends on the occupancy before that cycle's pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_bus | input | 16 | Shared half-word data bus |
| ld_lo | input | 1 | Low-half strobe, one cycle per pulse |
| ld_hi | input | 1 | High-half strobe, commits the assembled word |
| pop | input | 1 | Serializer request for the next word |
| rd_valid | output | 1 | Pulses one cycle after a pop that found a word |
| rd_word | output | 31 | Word returned by the last successful pop |
| tx_ready | output | 1 | High while no words are held |

## Verification
The first pattern runs short load-then-drain sequences. These separate the half placement and the commit order, and show the exact cycles in which the ready flag falls and rises. Further patterns cover isolated high-half strobes, repeated low-half strobes, bit 15 set during a high half, and strobes that coincide. Each one distinguishes correct pending-half handling from a design that commits stale or spurious data. A fill past eight words, followed by a drain and an extra pop, tells a dropping queue apart from one that overwrites or wraps. A long pseudo-random mix of strobes and pops, with the queue near full, then exercises commits and pops that land in the same cycle.

// File: rtl/txb_pkg.sv
package txb_pkg;
  localparam int TXB_WORD_W = 31;
  localparam int TXB_BUS_W  = 16;
  localparam int TXB_DEPTH  = 8;

  typedef enum logic {
    HALF_NONE = 1'b0,
    HALF_HELD = 1'b1
  } half_state_e;
endpackage

// File: rtl/txb_half_assembler.sv
module txb_half_assembler #(
  parameter int WORD_W = 31,
  parameter int BUS_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BUS_W-1:0]  bus,
  input  logic              ld_lo,
  input  logic              ld_hi,
  output logic              commit,
  output logic [WORD_W-1:0] word
);
  import txb_pkg::*;
  localparam int HI_W = WORD_W - BUS_W;

  half_state_e      state;
  logic [BUS_W-1:0] lo_hold;

  // A high-half strobe only counts when a low half is waiting.
  assign commit = ld_hi && (state == HALF_HELD);
  assign word   = {bus[HI_W-1:0], lo_hold};

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= HALF_NONE;
      lo_hold <= '0;
    end else begin
      if (ld_hi)
        state <= HALF_NONE;
      if (ld_lo) begin
        state   <= HALF_HELD;
        lo_hold <= bus;
      end
    end
  end

  // R6: a high-half strobe without a new low half leaves nothing pending.
  p_hi_clears_pending_r6: assert property (@(posedge clk) disable iff (rst)
    (ld_hi && !ld_lo) |=> (state == HALF_NONE));

  // R7: a low-half strobe always leaves its bus value pending.
  p_lo_captured_r7: assert property (@(posedge clk) disable iff (rst)
    ld_lo |=> (state == HALF_HELD) && (lo_hold == $past(bus)));
endmodule

// File: rtl/txb_occupancy.sv
module txb_occupancy #(
  parameter int DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_req,
  input  logic                     rd_req,
  output logic                     wr_en,
  output logic                     rd_en,
  output logic [$clog2(DEPTH)-1:0] wr_ptr,
  output logic [$clog2(DEPTH)-1:0] rd_ptr,
  output logic                     ready
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);

  logic [CW-1:0] count;
  logic [CW-1:0] count_nx;

  // Fullness and emptiness are judged on the count before this cycle's traffic.
  assign wr_en = wr_req && (count != FULL_CNT);
  assign rd_en = rd_req && (count != '0);

  always_comb begin
    count_nx = count;
    if (wr_en && !rd_en)
      count_nx = count + 1'b1;
    else if (rd_en && !wr_en)
      count_nx = count - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count  <= '0;
      wr_ptr <= '0;
      rd_ptr <= '0;
      ready  <= 1'b1;
    end else begin
      count <= count_nx;
      ready <= (count_nx == '0);
      if (wr_en)
        wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
      if (rd_en)
        rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
    end
  end

  // R3: the count never exceeds the capacity.
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    count <= FULL_CNT);

  // R4: an attempt on a full queue leaves the write pointer where it was.
  p_full_drop_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_req && count == FULL_CNT) |=> $stable(wr_ptr));

  // R5: the ready flag agrees with an empty count.
  p_ready_empty_r5: assert property (@(posedge clk) disable iff (rst)
    ready == (count == '0));

  // R9: a pop on an empty queue moves nothing.
  p_pop_empty_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !wr_req && count == '0) |=> $stable(rd_ptr) && ready);
endmodule

// File: rtl/txb_word_ram.sv
module txb_word_ram #(
  parameter int WORD_W = 31,
  parameter int DEPTH  = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_ptr,
  input  logic [WORD_W-1:0]        wr_word,
  input  logic                     rd_en,
  input  logic [$clog2(DEPTH)-1:0] rd_ptr,
  output logic [WORD_W-1:0]        rd_word,
  output logic                     rd_valid
);
  logic [WORD_W-1:0] mem [DEPTH];

  // Plain write port and registered read port, no reset on the array.
  always_ff @(posedge clk) begin
    if (wr_en)
      mem[wr_ptr] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (rd_en)
      rd_word <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst)
      rd_valid <= 1'b0;
    else
      rd_valid <= rd_en;
  end

  // R2: a returned word is held until the next successful pop.
  p_word_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_en) |-> $stable(rd_word));
endmodule

// File: rtl/txb_two_strobe_buffer.sv
module txb_two_strobe_buffer #(
  parameter int WORD_W = txb_pkg::TXB_WORD_W,
  parameter int BUS_W  = txb_pkg::TXB_BUS_W,
  parameter int DEPTH  = txb_pkg::TXB_DEPTH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BUS_W-1:0]  host_bus,
  input  logic              ld_lo,
  input  logic              ld_hi,
  input  logic              pop,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_word,
  output logic              tx_ready
);
  localparam int PW = $clog2(DEPTH);

  logic              commit;
  logic [WORD_W-1:0] asm_word;
  logic              wr_en;
  logic              rd_en;
  logic [PW-1:0]     wr_ptr;
  logic [PW-1:0]     rd_ptr;

  txb_half_assembler #(.WORD_W(WORD_W), .BUS_W(BUS_W)) u_asm (
    .clk    (clk),
    .rst    (rst),
    .bus    (host_bus),
    .ld_lo  (ld_lo),
    .ld_hi  (ld_hi),
    .commit (commit),
    .word   (asm_word)
  );

  txb_occupancy #(.DEPTH(DEPTH)) u_occ (
    .clk    (clk),
    .rst    (rst),
    .wr_req (commit),
    .rd_req (pop),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .wr_ptr (wr_ptr),
    .rd_ptr (rd_ptr),
    .ready  (tx_ready)
  );

  txb_word_ram #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_ram (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_ptr   (wr_ptr),
    .wr_word  (asm_word),
    .rd_en    (rd_en),
    .rd_ptr   (rd_ptr),
    .rd_word  (rd_word),
    .rd_valid (rd_valid)
  );

  // R5: the first commit into an empty queue drops the ready flag.
  p_commit_clears_ready_r5: assert property (@(posedge clk) disable iff (rst)
    (tx_ready && commit && !pop) |=> !tx_ready);

  // R9: a pop while ready brings no valid word.
  p_no_valid_when_empty_r9: assert property (@(posedge clk) disable iff (rst)
    (tx_ready && pop) |=> !rd_valid);

  // R10: the cycle after reset shows an empty, idle buffer.
  p_reset_state_r10: assert property (@(posedge clk)
    $past(rst) |-> tx_ready && !rd_valid);
endmodule

// File: tb/tb_txb_two_strobe_buffer.sv
`timescale 1ns/1ps
module tb_txb_two_strobe_buffer;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] host_bus;
  logic        ld_lo, ld_hi, pop;
  logic        rd_valid;
  logic [30:0] rd_word;
  logic        tx_ready;

  int compared = 0;
  int mismatched = 0;

  logic [30:0] q[$];
  logic        m_pend;
  logic [15:0] m_lo;
  logic        e_valid;
  logic [30:0] e_word;
  logic [15:0] lfsr;

  always #2.5 clk = ~clk;

  txb_two_strobe_buffer dut (
    .clk(clk), .rst(rst), .host_bus(host_bus), .ld_lo(ld_lo), .ld_hi(ld_hi),
    .pop(pop), .rd_valid(rd_valid), .rd_word(rd_word), .tx_ready(tx_ready)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock: drive at the falling edge, update the model at the rising edge,
  // compare at the next falling edge.
  task automatic step(logic lo, logic hi, logic [15:0] b, logic p, string tag);
    int sz0;
    host_bus = b; ld_lo = lo; ld_hi = hi; pop = p;
    @(posedge clk);
    sz0 = q.size();
    e_valid = 1'b0;
    if (p && sz0 > 0) begin
      e_valid = 1'b1;
      e_word  = q.pop_front();
    end
    if (hi && m_pend && sz0 < 8)
      q.push_back({b[14:0], m_lo});
    if (hi) m_pend = 1'b0;
    if (lo) begin m_pend = 1'b1; m_lo = b; end
    @(negedge clk);
    check({tag, " ready R5"}, {31'd0, tx_ready}, {31'd0, (q.size() == 0)});
    check({tag, " valid R2"}, {31'd0, rd_valid}, {31'd0, e_valid});
    if (e_valid)
      check({tag, " word R1"}, {1'b0, rd_word}, {1'b0, e_word});
  endtask

  task automatic load(logic [30:0] w, string tag);
    step(1'b1, 1'b0, w[15:0], 1'b0, tag);
    step(1'b0, 1'b1, {1'b0, w[30:16]}, 1'b0, tag);
  endtask

  task automatic drain(string tag);
    while (q.size() > 0) step(1'b0, 1'b0, 16'h0, 1'b1, tag);
  endtask

  initial begin
    #(5.0 * 150000);
    mismatched++;
    $display("FAIL watchdog R10 actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    m_pend = 1'b0; m_lo = '0; lfsr = 16'hACE1;
    host_bus = '0; ld_lo = 0; ld_hi = 0; pop = 0; rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    check("reset ready R10", {31'd0, tx_ready}, 32'd1);
    check("reset valid R10", {31'd0, rd_valid}, 32'd0);

    // R1 R2 R5: basic loads and drain
    load(31'h1234_5678, "R1 basic");
    load(31'h7FFF_0001, "R2 order");
    load(31'h0000_FFFF, "R2 order");
    drain("R2 drain");

    // R6: high half alone
    step(1'b0, 1'b1, 16'h1111, 1'b0, "R6 lone hi");
    step(1'b0, 1'b0, 16'h0, 1'b1, "R6 pop");

    // R7: low half replaced
    step(1'b1, 1'b0, 16'hAAAA, 1'b0, "R7 lo1");
    step(1'b1, 1'b0, 16'h5555, 1'b0, "R7 lo2");
    step(1'b0, 1'b1, 16'h0123, 1'b0, "R7 hi");
    drain("R7 drain");

    // R8: bus bit 15 during high half
    step(1'b1, 1'b0, 16'h00F0, 1'b0, "R8 lo");
    step(1'b0, 1'b1, 16'h8002, 1'b0, "R8 hi");
    drain("R8 drain");

    // R3 R4: fill, overfill, drain, extra pop (R9)
    for (int i = 0; i < 8; i++) load(31'(32'h0101_0101 * (i + 1)), "R3 fill");
    load(31'h7EAD_BEEF, "R4 overfill");
    drain("R4 drain");
    step(1'b0, 1'b0, 16'h0, 1'b1, "R9 empty pop");
    step(1'b0, 1'b0, 16'h0, 1'b1, "R9 empty pop");

    // R11: coincident strobes
    step(1'b1, 1'b0, 16'h1357, 1'b0, "R11 lo");
    step(1'b1, 1'b1, 16'h2468, 1'b0, "R11 both");
    step(1'b0, 1'b1, 16'h0ABC, 1'b0, "R11 hi");
    drain("R11 drain");

    // R12: pop and commit together, also at full
    load(31'h0000_0042, "R12 pre");
    step(1'b1, 1'b0, 16'h9999, 1'b0, "R12 lo");
    step(1'b0, 1'b1, 16'h0007, 1'b1, "R12 both");
    drain("R12 drain");
    for (int i = 0; i < 8; i++) load(31'(i + 100), "R12 fill");
    step(1'b1, 1'b0, 16'hCAFE, 1'b0, "R12 lo full");
    step(1'b0, 1'b1, 16'h0011, 1'b1, "R12 full pop");
    drain("R12 drain full");

    // Pseudo-random mix
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0], lfsr[1], {lfsr[7:0], lfsr[15:8]}, lfsr[2] & lfsr[3], "R12 random");
    end
    drain("R2 final");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule